// File: doc/BRIEF.md
# Nibble-wide load/store unit with register-pair addressing

This unit carries out the memory load and store commands of a small 8-bit processor whose external memory is only four bits wide. It owns the processor's sixteen 8-bit registers. The two lowest registers together hold the 16-bit program counter. Any even-numbered register, together with the register just above it, can serve as a 16-bit memory pointer. A load brings one nibble from memory into the low half of a register. A store sends the low half of a register out to memory.

A command is given with a one-cycle start pulse. It carries a direction bit, a data register number and a pointer register number. The unit then makes one access cycle on the nibble memory port and raises done for exactly one cycle. When the pointer is the program-counter pair, the pair is stepped by one after the access. A program can then keep constants inline in its instruction stream and read them with an ordinary load. A general write port lets the rest of the processor update registers, and a combinational read port lets it read them.

Top module: `nibble_lsu`

## Requirements
- R1: After reset all sixteen registers read 0, and done_o, err_o and mem_we_o are low.
- R2: A start seen while idle with an even pointer p is followed, in the next cycle only, by the access cycle. In that cycle mem_addr_o = {reg[p+1], reg[p]}, with reg[p+1] as bits 15:8. Outside the access cycle mem_addr_o is 0.
- R3: A load (store_i=0) writes {4'b0000, mem_rdata_i sampled in the access cycle} into the data register. The new value is readable from the done cycle on.
- R4: A store (store_i=1) asserts mem_we_o only in its access cycle. It drives mem_wdata_o with bits 3:0 of the data register in that cycle, and 0 at all other times. Bits 7:4 play no part, and no register changes.
- R5: done_o is high for exactly the one cycle after the access cycle. start_i is ignored while a command is in progress, including its done cycle.
- R6: A command with an odd pointer (bit 0 = 1) makes no access cycle. done_o and err_o are both high in the cycle after start, and no register changes. err_o is never high without done_o.
- R7: When the pointer is 0, the 16-bit value {reg1, reg0} is raised by one at the end of the access cycle. The carry goes from reg0 into reg1, and 0xFFFF wraps to 0x0000. This applies to both loads and stores.
- R8: A load through pointer 0 writes its data register in the same cycle as the step. If that data register is reg0 or reg1, the stepped value is what remains.
- R9: wr_en_i writes wr_data_i into register wr_sel_i at the clock edge, and rd_data_o shows register rd_sel_i combinationally. If an internal load or step writes the same register in the same cycle, the internal write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Command request, taken only while idle |
| store_i | input | 1 | 1 = store, 0 = load |
| reg_sel_i | input | 4 | Data register of the command |
| ptr_sel_i | input | 4 | Pointer register of the command, must be even |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Odd-pointer rejection, qualified by done_o |
| wr_en_i | input | 1 | General register write enable |
| wr_sel_i | input | 4 | General write register number |
| wr_data_i | input | 8 | General write data |
| rd_sel_i | input | 4 | Read port register number |
| rd_data_o | output | 8 | Read port data |
| mem_addr_o | output | 16 | Memory nibble address |
| mem_wdata_o | output | 4 | Memory write nibble |
| mem_we_o | output | 1 | Memory write enable |
| mem_rdata_i | input | 4 | Memory read nibble |

## Verification
A wrong control state shows at the ports within one cycle. A missing, doubled or early access cycle shows up at once as a non-zero address, or as a write enable or done pulse in the wrong cycle. A corrupted register or a lost program-counter carry stays hidden until that register is read or used as a pointer. The bench therefore keeps a behavioural copy of every register and compares the read port and the memory port against it on every clock. It also sweeps pointers, including through the program-counter pair, so that such faults reach the address bus within a few commands.

// File: rtl/nlsu_pkg.sv
package nlsu_pkg;
  localparam int unsigned LSU_DW   = 8;
  localparam int unsigned LSU_NW   = 4;
  localparam int unsigned LSU_NREG = 16;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_DONE   = 2'd2
  } lsu_state_e;
endpackage

// File: rtl/nlsu_regfile.sv
module nlsu_regfile #(
  parameter int unsigned NREG = 16,
  parameter int unsigned DW   = 8,
  localparam int unsigned SELW = $clog2(NREG)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ext_we_i,
  input  logic [SELW-1:0]            ext_sel_i,
  input  logic [DW-1:0]              ext_data_i,
  input  logic                       ld_we_i,
  input  logic [SELW-1:0]            ld_sel_i,
  input  logic [DW-1:0]              ld_data_i,
  input  logic                       pc_we_i,
  input  logic [2*DW-1:0]            pc_val_i,
  output logic [NREG-1:0][DW-1:0]    regs_o
);
  // Priority per register: counter step, then load result, then general port.
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [DW-1:0] r;
    logic          ld_hit;
    logic          ext_hit;
    assign ld_hit  = ld_we_i  && (ld_sel_i  == SELW'(i));
    assign ext_hit = ext_we_i && (ext_sel_i == SELW'(i));
    if (i < 2) begin : g_pc
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       r <= '0;
        else if (pc_we_i) r <= pc_val_i[i*DW +: DW];
        else if (ld_hit)  r <= ld_data_i;
        else if (ext_hit) r <= ext_data_i;
      end
    end else begin : g_gp
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       r <= '0;
        else if (ld_hit)  r <= ld_data_i;
        else if (ext_hit) r <= ext_data_i;
      end
    end
    assign regs_o[i] = r;
  end
endmodule

// File: rtl/nlsu_ctrl.sv
module nlsu_ctrl
  import nlsu_pkg::*;
#(
  parameter int unsigned SELW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            store_i,
  input  logic [SELW-1:0] reg_sel_i,
  input  logic [SELW-1:0] ptr_sel_i,
  output logic            busy_o,
  output logic            access_o,
  output logic            done_o,
  output logic            err_o,
  output logic            store_q_o,
  output logic [SELW-1:0] reg_q_o,
  output logic [SELW-1:0] ptr_q_o
);
  lsu_state_e      state;
  logic            err_q;
  logic            store_q;
  logic [SELW-1:0] reg_q;
  logic [SELW-1:0] ptr_q;
  logic            accept;
  logic            ptr_odd;

  assign accept  = (state == ST_IDLE) && start_i;
  assign ptr_odd = ptr_sel_i[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      err_q   <= 1'b0;
      store_q <= 1'b0;
      reg_q   <= '0;
      ptr_q   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            store_q <= store_i;
            reg_q   <= reg_sel_i;
            ptr_q   <= ptr_sel_i;
            err_q   <= ptr_odd;
            state   <= ptr_odd ? ST_DONE : ST_ACCESS;
          end
        end
        ST_ACCESS: state <= ST_DONE;
        default: begin
          state <= ST_IDLE;
          err_q <= 1'b0;
        end
      endcase
    end
  end

  assign busy_o    = (state != ST_IDLE);
  assign access_o  = (state == ST_ACCESS);
  assign done_o    = (state == ST_DONE);
  assign err_o     = done_o && err_q;
  assign store_q_o = store_q;
  assign reg_q_o   = reg_q;
  assign ptr_q_o   = ptr_q;
endmodule

// File: rtl/nlsu_addr.sv
module nlsu_addr #(
  parameter int unsigned DW = 8,
  parameter int unsigned NW = 4,
  localparam int unsigned AW = 2*DW
) (
  input  logic          access_i,
  input  logic          store_i,
  input  logic          ptr_is_pc_i,
  input  logic [DW-1:0] ptr_lo_i,
  input  logic [DW-1:0] ptr_hi_i,
  input  logic [DW-1:0] src_i,
  input  logic [NW-1:0] rdata_i,
  output logic [AW-1:0] addr_o,
  output logic [NW-1:0] wdata_o,
  output logic          we_o,
  output logic          pc_we_o,
  output logic [AW-1:0] pc_next_o,
  output logic          ld_we_o,
  output logic [DW-1:0] ld_data_o
);
  function automatic logic [AW-1:0] join_pair(input logic [DW-1:0] hi,
                                               input logic [DW-1:0] lo);
    return {hi, lo};
  endfunction

  function automatic logic [AW-1:0] step_pair(input logic [AW-1:0] v);
    return v + AW'(1);
  endfunction

  function automatic logic [DW-1:0] widen_nibble(input logic [NW-1:0] n);
    return {{(DW-NW){1'b0}}, n};
  endfunction

  logic [AW-1:0] pointer;
  assign pointer   = join_pair(ptr_hi_i, ptr_lo_i);

  assign addr_o    = access_i ? pointer : '0;
  assign we_o      = access_i && store_i;
  assign wdata_o   = we_o ? src_i[NW-1:0] : '0;
  assign pc_we_o   = access_i && ptr_is_pc_i;
  assign pc_next_o = step_pair(pointer);
  assign ld_we_o   = access_i && !store_i;
  assign ld_data_o = widen_nibble(rdata_i);
endmodule

// File: rtl/nibble_lsu.sv
module nibble_lsu #(
  parameter int unsigned DW   = nlsu_pkg::LSU_DW,
  parameter int unsigned NW   = nlsu_pkg::LSU_NW,
  parameter int unsigned NREG = nlsu_pkg::LSU_NREG,
  localparam int unsigned SELW = $clog2(NREG),
  localparam int unsigned AW   = 2*DW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            store_i,
  input  logic [SELW-1:0] reg_sel_i,
  input  logic [SELW-1:0] ptr_sel_i,
  output logic            done_o,
  output logic            err_o,
  input  logic            wr_en_i,
  input  logic [SELW-1:0] wr_sel_i,
  input  logic [DW-1:0]   wr_data_i,
  input  logic [SELW-1:0] rd_sel_i,
  output logic [DW-1:0]   rd_data_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [NW-1:0]   mem_wdata_o,
  output logic            mem_we_o,
  input  logic [NW-1:0]   mem_rdata_i
);
  logic                    busy;
  logic                    access;
  logic                    store_q;
  logic [SELW-1:0]         reg_q;
  logic [SELW-1:0]         ptr_q;
  logic [NREG-1:0][DW-1:0] regs;
  logic [SELW-1:0]         ptr_hi_sel;
  logic                    ptr_is_pc;
  logic                    pc_we;
  logic [AW-1:0]           pc_next;
  logic                    ld_we;
  logic [DW-1:0]           ld_data;

  // Named internal events for the checker.
  logic                    pc_bump;
  logic                    ld_wb;
  logic [AW-1:0]           pc_now;
  logic [DW-1:0]           dst_now;
  logic                    dst_is_pc;

  nlsu_ctrl #(.SELW(SELW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .store_i   (store_i),
    .reg_sel_i (reg_sel_i),
    .ptr_sel_i (ptr_sel_i),
    .busy_o    (busy),
    .access_o  (access),
    .done_o    (done_o),
    .err_o     (err_o),
    .store_q_o (store_q),
    .reg_q_o   (reg_q),
    .ptr_q_o   (ptr_q)
  );

  assign ptr_hi_sel = ptr_q | SELW'(1);
  assign ptr_is_pc  = (ptr_q == '0);

  nlsu_addr #(.DW(DW), .NW(NW)) u_addr (
    .access_i    (access),
    .store_i     (store_q),
    .ptr_is_pc_i (ptr_is_pc),
    .ptr_lo_i    (regs[ptr_q]),
    .ptr_hi_i    (regs[ptr_hi_sel]),
    .src_i       (regs[reg_q]),
    .rdata_i     (mem_rdata_i),
    .addr_o      (mem_addr_o),
    .wdata_o     (mem_wdata_o),
    .we_o        (mem_we_o),
    .pc_we_o     (pc_we),
    .pc_next_o   (pc_next),
    .ld_we_o     (ld_we),
    .ld_data_o   (ld_data)
  );

  nlsu_regfile #(.NREG(NREG), .DW(DW)) u_rf (
    .clk        (clk),
    .rst_n      (rst_n),
    .ext_we_i   (wr_en_i),
    .ext_sel_i  (wr_sel_i),
    .ext_data_i (wr_data_i),
    .ld_we_i    (ld_we),
    .ld_sel_i   (reg_q),
    .ld_data_i  (ld_data),
    .pc_we_i    (pc_we),
    .pc_val_i   (pc_next),
    .regs_o     (regs)
  );

  assign rd_data_o = regs[rd_sel_i];

  assign pc_bump   = pc_we;
  assign ld_wb     = ld_we;
  assign pc_now    = {regs[1], regs[0]};
  assign dst_now   = regs[reg_q];
  assign dst_is_pc = (reg_q[SELW-1:1] == '0);
endmodule

// File: rtl/nlsu_checker.sv
module nlsu_checker #(
  parameter int unsigned DW   = 8,
  parameter int unsigned NW   = 4,
  parameter int unsigned SELW = 4,
  localparam int unsigned AW  = 2*DW
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start_i,
  input logic [SELW-1:0] ptr_sel_i,
  input logic            busy,
  input logic            access,
  input logic            done_o,
  input logic            err_o,
  input logic            mem_we_o,
  input logic [AW-1:0]   mem_addr_o,
  input logic [NW-1:0]   mem_rdata_i,
  input logic            pc_bump,
  input logic [AW-1:0]   pc_now,
  input logic            ld_wb,
  input logic [DW-1:0]   dst_now,
  input logic            dst_is_pc
);
  p_addr_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !access |-> (mem_addr_o == '0));

  p_load_zext_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_wb && !(pc_bump && dst_is_pc)) |=>
      (dst_now == {{(DW-NW){1'b0}}, $past(mem_rdata_i)}));

  p_we_then_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |=> (done_o && !mem_we_o));

  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_odd_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy && ptr_sel_i[0]) |=> (done_o && err_o && !access));

  p_err_needs_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> done_o);

  p_pc_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pc_bump |=> (pc_now == $past(mem_addr_o) + AW'(1)));
endmodule

bind nibble_lsu nlsu_checker #(.DW(DW), .NW(NW), .SELW(SELW)) u_nlsu_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .ptr_sel_i   (ptr_sel_i),
  .busy        (busy),
  .access      (access),
  .done_o      (done_o),
  .err_o       (err_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_rdata_i (mem_rdata_i),
  .pc_bump     (pc_bump),
  .pc_now      (pc_now),
  .ld_wb       (ld_wb),
  .dst_now     (dst_now),
  .dst_is_pc   (dst_is_pc)
);

// File: tb/tb_nibble_lsu.sv
`timescale 1ns/1ps
module tb_nibble_lsu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0, store_i = 1'b0;
  logic [3:0]  reg_sel_i = '0, ptr_sel_i = '0;
  logic        done_o, err_o;
  logic        wr_en_i = 1'b0;
  logic [3:0]  wr_sel_i = '0;
  logic [7:0]  wr_data_i = '0;
  logic [3:0]  rd_sel_i = '0;
  logic [7:0]  rd_data_o;
  logic [15:0] mem_addr_o;
  logic [3:0]  mem_wdata_o;
  logic        mem_we_o;
  logic [3:0]  mem_rdata_i;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  nibble_lsu dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .store_i(store_i),
    .reg_sel_i(reg_sel_i), .ptr_sel_i(ptr_sel_i), .done_o(done_o), .err_o(err_o),
    .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
    .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_we_o(mem_we_o), .mem_rdata_i(mem_rdata_i)
  );

  // Memory content as a function of the address.
  function automatic int mem_f(input int a);
    return ((a & 15) ^ ((a >> 4) & 15) ^ ((a >> 8) & 15) ^ ((a >> 12) & 15) ^ 5) & 15;
  endfunction
  assign mem_rdata_i = 4'(mem_f(int'(mem_addr_o)));

  // Behavioural reference: phase 0 idle, 1 access, 2 done, 3 rejected done.
  int m [16];
  int phase = 0;
  int c_st = 0, c_reg = 0, c_ptr = 0;

  always @(posedge clk) begin
    int a, ld;
    if (!rst_n) begin
      foreach (m[k]) m[k] = 0;
      phase = 0;
    end else begin
      a  = m[c_ptr + 1] * 256 + m[c_ptr];
      ld = mem_f(a);
      if (wr_en_i) m[wr_sel_i] = int'(wr_data_i);
      case (phase)
        0: if (start_i) begin
             c_st = int'(store_i); c_reg = int'(reg_sel_i); c_ptr = int'(ptr_sel_i);
             phase = (c_ptr % 2 == 1) ? 3 : 1;
           end
        1: begin
             if (c_st == 0) m[c_reg] = ld;
             if (c_ptr == 0) begin
               a = (a + 1) % 65536;
               m[0] = a % 256;
               m[1] = a / 256;
             end
             phase = 2;
           end
        default: phase = 0;
      endcase
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison, sampled away from the rising edge.
  always @(negedge clk) begin
    int ea, ew;
    #5;
    if (rst_n && !finished) begin
      ea = (phase == 1) ? m[c_ptr + 1] * 256 + m[c_ptr] : 0;
      ew = (phase == 1 && c_st == 1) ? (m[c_reg] & 15) : 0;
      check(int'(mem_addr_o) == ea, "R2 addr", int'(mem_addr_o), ea);
      check(int'(mem_wdata_o) == ew, "R4 wdata", int'(mem_wdata_o), ew);
      check(int'(mem_we_o) == int'(phase == 1 && c_st == 1), "R4 we",
            int'(mem_we_o), int'(phase == 1 && c_st == 1));
      check(int'(done_o) == int'(phase >= 2), "R5 done", int'(done_o), int'(phase >= 2));
      check(int'(err_o) == int'(phase == 3), "R6 err", int'(err_o), int'(phase == 3));
      check(int'(rd_data_o) == m[rd_sel_i], "R9 read", int'(rd_data_o), m[rd_sel_i]);
    end
  end

  task automatic peek(input int sel, output int v);
    @(negedge clk);
    rd_sel_i = 4'(sel);
    #6;
    v = int'(rd_data_o);
  endtask

  task automatic put(input int sel, input int val);
    @(negedge clk);
    wr_en_i = 1'b1; wr_sel_i = 4'(sel); wr_data_i = 8'(val);
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic cmd(input bit st, input int r, input int p);
    @(negedge clk);
    start_i = 1'b1; store_i = st; reg_sel_i = 4'(r); ptr_sel_i = 4'(p);
    @(negedge clk);
    start_i = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin : stim
    int v;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(done_o == 1'b0 && err_o == 1'b0 && mem_we_o == 1'b0, "R1 outputs",
          int'({done_o, err_o, mem_we_o}), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 16; i++) begin
      peek(i, v);
      check(v == 0, "R1 reg", v, 0);
    end

    // R3: load through pointer pair 3:2
    put(2, 8'h34); put(3, 8'h12); put(8, 8'hF0);
    cmd(1'b0, 8, 2);
    peek(8, v);
    check(v == mem_f(16'h1234), "R3 load zext", v, mem_f(16'h1234));

    // R4: store, high nibble plays no part, no register change
    put(4, 8'hCD); put(5, 8'hAB); put(9, 8'hA7);
    cmd(1'b1, 9, 4);
    peek(9, v);
    check(v == 8'hA7, "R4 src kept", v, 8'hA7);

    // R6: odd pointer rejected
    cmd(1'b0, 9, 3);
    peek(9, v);
    check(v == 8'hA7, "R6 no write", v, 8'hA7);

    // R7 and R8: program-counter pointer with carry
    put(0, 8'hFF); put(1, 8'h12);
    cmd(1'b0, 10, 0);
    peek(10, v);
    check(v == mem_f(16'h12FF), "R8 load via pc", v, mem_f(16'h12FF));
    peek(1, v);
    check(v == 8'h13, "R7 carry high", v, 8'h13);
    peek(0, v);
    check(v == 8'h00, "R7 carry low", v, 8'h00);

    // R7: wrap on store
    put(0, 8'hFF); put(1, 8'hFF);
    cmd(1'b1, 9, 0);
    peek(1, v);
    check(v == 0, "R7 wrap high", v, 0);
    peek(0, v);
    check(v == 0, "R7 wrap low", v, 0);

    // R8: load into reg0 through pointer 0, step wins
    put(0, 8'h10); put(1, 8'h00);
    cmd(1'b0, 0, 0);
    peek(0, v);
    check(v == 8'h11, "R8 pc wins", v, 8'h11);

    // R9: general write in the access cycle loses to the load
    @(negedge clk);
    start_i = 1'b1; store_i = 1'b0; reg_sel_i = 4'd8; ptr_sel_i = 4'd2;
    @(negedge clk);
    start_i = 1'b0; wr_en_i = 1'b1; wr_sel_i = 4'd8; wr_data_i = 8'hEE;
    @(negedge clk);
    wr_en_i = 1'b0;
    @(negedge clk);
    peek(8, v);
    check(v == mem_f(16'h1234), "R9 internal wins", v, mem_f(16'h1234));

    // R5: start held high across whole commands
    @(negedge clk);
    start_i = 1'b1; store_i = 1'b1; reg_sel_i = 4'd9; ptr_sel_i = 4'd4;
    repeat (7) @(negedge clk);
    start_i = 1'b0;
    repeat (4) @(negedge clk);

    // Mixed traffic, compared every cycle against the model
    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(0, 3) == 0) put($urandom_range(0, 15), $urandom_range(0, 255));
      rd_sel_i = 4'($urandom_range(0, 15));
      cmd(1'($urandom_range(0, 1)), $urandom_range(0, 15),
          ($urandom_range(0, 4) == 0) ? 0 : $urandom_range(0, 15));
    end

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule